// File: doc/BRIEF.md
# I2C SCL Tap-Structure Timing Generator

This block produces the bit timing for an I2C master from a 6-bit divider code. The code is not a plain power-of-two divide. Two 3-bit indices are gathered from scattered bits of the code. One index picks a pair of tap counts: one for the SCL period and one for the SDA hold. The other index picks a base delay and a tap-to-tap step. From these the block derives the SCL period, which is split into equal low and high halves, and an SDA hold delay counted from each SCL fall. All values are in system clocks.

While the block is enabled and a run is requested, it emits a one-cycle `scl_fall_o` strobe at the start of every period, `scl_rise_o` at mid-period and `sda_change_o` once the hold delay has elapsed after the fall. The surrounding master drives the bus lines and shifts bits on these strobes. A divider code is taken while the timer is idle. A code that changes during a run takes effect only from the next period boundary, so a period in progress always completes with one consistent timing. Choosing a code for a target bit rate is left to software.

Top module: `i2c_scl_tap_timer`

## Requirements
- R1: The tap index is {code[5], code[1], code[0]} (code[5] most significant). Index values 0 to 7 give (SCL tap, SDA tap) of (9,3), (10,3), (12,4), (15,4), (5,1), (6,1), (7,2), (8,2).
- R2: The step index is code[4:2]. Index values 0 to 7 give a base delay of 4, 4, 6, 6, 14, 30, 62, 126 and a step of 2 to the power of the index.
- R3: Successive `scl_fall_o` strobes are spaced by the period P = 2 × (base + (SCL tap − 1) × step + 2) system clocks, for every one of the 64 codes.
- R4: `scl_rise_o` fires exactly P/2 clocks after each `scl_fall_o`.
- R5: `sda_change_o` fires exactly H = base + (SDA tap − 1) × step + 3 clocks after each `scl_fall_o`. H is always less than P/2.
- R6: Code 0x00 gives P=28 and H=9. Code 0x3F gives 2048 and 257. Code 0x20 gives the shortest period, 20 with H=7. Code 0x1F gives the longest, 3840 with H=513.
- R7: The first `scl_fall_o` of a run is high in the cycle after the first clock edge that samples both `enable_i` and `run_i` high (STROBE_REG extra cycles when the registered output variant is chosen).
- R8: The code is sampled on every idle clock edge. A change while running does not alter the period in progress, and it applies from the next period onward.
- R9: While `enable_i` or `run_i` is low, the counter is held at its start and no strobe is produced. A new run starts with a fresh period.
- R10: At most one of the three strobes is high in any cycle.
- R11: While `rst_n` is low, all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code_i | input | 6 | Divider code |
| enable_i | input | 1 | Block enable |
| run_i | input | 1 | Run request; timing runs while this and enable are high |
| scl_fall_o | output | 1 | One-cycle strobe: drive SCL low (start of period) |
| scl_rise_o | output | 1 | One-cycle strobe: release SCL high (mid-period) |
| sda_change_o | output | 1 | One-cycle strobe: SDA may change (hold elapsed) |

## Verification
The hardest situation to reach is a code change that lands in the middle of a running period. The timing must keep the old code up to the boundary and then switch cleanly. The bench reaches it by changing the code from the same process that counts cycles, a few clocks after the first fall. It then measures the first period, which uses the old code, and the second period, including its rise point, which uses the new code. All 64 codes are also swept, each for a full period, and every measured interval is compared with values the bench computes from the tap and step arithmetic.

// File: rtl/i2c_tap_pkg.sv
`timescale 1ns/1ps
package i2c_tap_pkg;

   localparam int CODE_W     = 6;
   localparam int IDX_W      = 3;
   localparam int MAX_PERIOD = 3840;
   localparam int MIN_CNT_W  = $clog2(MAX_PERIOD);

   typedef struct packed {
      logic [IDX_W-1:0] tap_idx;
      logic [IDX_W-1:0] step_idx;
   } code_split_t;

   function automatic code_split_t split_code(input logic [CODE_W-1:0] c);
      code_split_t s;
      s.tap_idx  = {c[5], c[1], c[0]};
      s.step_idx = c[4:2];
      return s;
   endfunction

   function automatic logic [31:0] scl_tap(input logic [IDX_W-1:0] i);
      case (i)
         3'd0:    return 32'd9;
         3'd1:    return 32'd10;
         3'd2:    return 32'd12;
         3'd3:    return 32'd15;
         3'd4:    return 32'd5;
         3'd5:    return 32'd6;
         3'd6:    return 32'd7;
         default: return 32'd8;
      endcase
   endfunction

   function automatic logic [31:0] sda_tap(input logic [IDX_W-1:0] i);
      case (i)
         3'd0, 3'd1: return 32'd3;
         3'd2, 3'd3: return 32'd4;
         3'd4, 3'd5: return 32'd1;
         default:    return 32'd2;
      endcase
   endfunction

   function automatic logic [31:0] base_delay(input logic [IDX_W-1:0] i);
      case (i)
         3'd0, 3'd1: return 32'd4;
         3'd2, 3'd3: return 32'd6;
         default:    return (32'd1 << i) - 32'd2;
      endcase
   endfunction

endpackage

// File: rtl/i2c_tap_code_decode.sv
`timescale 1ns/1ps
module i2c_tap_code_decode
   import i2c_tap_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CNT_W-1:0]  half_o,
   output logic [CNT_W-1:0]  hold_o,
   output logic [CNT_W-1:0]  last_o
);

   code_split_t split;
   logic [31:0] half_w, hold_w, last_w;

   always_comb begin
      split  = split_code(code_i);
      half_w = base_delay(split.step_idx)
             + ((scl_tap(split.tap_idx) - 32'd1) << split.step_idx) + 32'd2;
      hold_w = base_delay(split.step_idx)
             + ((sda_tap(split.tap_idx) - 32'd1) << split.step_idx) + 32'd3;
      last_w = (half_w << 1) - 32'd1;
   end

   assign half_o = half_w[CNT_W-1:0];
   assign hold_o = hold_w[CNT_W-1:0];
   assign last_o = last_w[CNT_W-1:0];

endmodule

// File: rtl/i2c_tap_phase_counter.sv
`timescale 1ns/1ps
module i2c_tap_phase_counter
   import i2c_tap_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [CNT_W-1:0]  last_i,
   output logic [CODE_W-1:0] code_q_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              running_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_o <= 1'b0;
         cnt_o     <= '0;
         code_q_o  <= '0;
      end else if (!active_i) begin
         running_o <= 1'b0;
         cnt_o     <= '0;
         code_q_o  <= code_i;
      end else if (!running_o) begin
         running_o <= 1'b1;
      end else if (cnt_o == last_i) begin
         cnt_o     <= '0;
         code_q_o  <= code_i;
      end else begin
         cnt_o     <= cnt_o + 1'b1;
      end
   end

endmodule

// File: rtl/i2c_tap_strobe_compare.sv
`timescale 1ns/1ps
module i2c_tap_strobe_compare #(
   parameter int CNT_W = 12
) (
   input  logic             running_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] half_i,
   input  logic [CNT_W-1:0] hold_i,
   output logic [2:0]       strobe_o
);

   localparam int FALL_BIT = 0;
   localparam int SDA_BIT  = 1;
   localparam int RISE_BIT = 2;

   always_comb begin
      strobe_o           = '0;
      strobe_o[FALL_BIT] = running_i && (cnt_i == '0);
      strobe_o[SDA_BIT]  = running_i && (cnt_i == hold_i);
      strobe_o[RISE_BIT] = running_i && (cnt_i == half_i);
   end

endmodule

// File: rtl/i2c_scl_tap_timer.sv
`timescale 1ns/1ps
module i2c_scl_tap_timer
   import i2c_tap_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int STROBE_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] div_code_i,
   input  logic              enable_i,
   input  logic              run_i,
   output logic              scl_fall_o,
   output logic              scl_rise_o,
   output logic              sda_change_o
);

   generate
      if (CNT_W < MIN_CNT_W || CNT_W > 32) begin : g_bad_width
         $error("CNT_W must lie between the longest-period width and 32");
      end
      if (STROBE_REG != 0 && STROBE_REG != 1) begin : g_bad_variant
         $error("STROBE_REG must be 0 or 1");
      end
   endgenerate

   logic              active;
   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  cnt, half, hold, last;
   logic              running;
   logic [2:0]        strobe_d;

   assign active = enable_i & run_i;

   i2c_tap_phase_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (active),
      .code_i    (div_code_i),
      .last_i    (last),
      .code_q_o  (code_q),
      .cnt_o     (cnt),
      .running_o (running)
   );

   i2c_tap_code_decode #(.CNT_W(CNT_W)) u_dec (
      .code_i (code_q),
      .half_o (half),
      .hold_o (hold),
      .last_o (last)
   );

   i2c_tap_strobe_compare #(.CNT_W(CNT_W)) u_cmp (
      .running_i (running),
      .cnt_i     (cnt),
      .half_i    (half),
      .hold_i    (hold),
      .strobe_o  (strobe_d)
   );

   generate
      if (STROBE_REG == 1) begin : g_reg_out
         logic [2:0] strobe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strobe_q <= '0;
            else        strobe_q <= strobe_d;
         end
         assign {scl_rise_o, sda_change_o, scl_fall_o} = strobe_q;
      end else begin : g_comb_out
         assign {scl_rise_o, sda_change_o, scl_fall_o} = strobe_d;
      end
   endgenerate

endmodule

// File: rtl/i2c_scl_tap_timer_chk.sv
`timescale 1ns/1ps
module i2c_scl_tap_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic enable_i,
   input logic run_i,
   input logic scl_fall_o,
   input logic scl_rise_o,
   input logic sda_change_o
);

   logic act;
   logic prev_idle;
   logic low_phase;

   assign act = enable_i & run_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_idle <= 1'b1;
         low_phase <= 1'b0;
      end else begin
         prev_idle <= !act;
         if (scl_fall_o)                low_phase <= 1'b1;
         else if (scl_rise_o)           low_phase <= 1'b0;
         else if (!act && prev_idle)    low_phase <= 1'b0;
      end
   end

   p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({scl_fall_o, scl_rise_o, sda_change_o}));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && prev_idle) |=> !(scl_fall_o || scl_rise_o || sda_change_o));

   p_rise_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise_o |-> low_phase);

   p_sda_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sda_change_o |-> low_phase);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r11: assert (!(scl_fall_o || scl_rise_o || sda_change_o));
      end
   end

endmodule

bind i2c_scl_tap_timer i2c_scl_tap_timer_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable_i     (enable_i),
   .run_i        (run_i),
   .scl_fall_o   (scl_fall_o),
   .scl_rise_o   (scl_rise_o),
   .sda_change_o (sda_change_o)
);

// File: tb/test_i2c_scl_tap_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_tap_timer;

   localparam int LAT = 0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] div_code = 6'd0;
   logic       enable = 1'b1;
   logic       run = 1'b1;
   logic       scl_fall, scl_rise, sda_change;

   int nchk = 0, nfail = 0;
   int f_t[4], r_t[4], s_t[4];
   int nf, nr, ns, t, multi;

   always #4 clk = ~clk;

   i2c_scl_tap_timer #(.CNT_W(12), .STROBE_REG(LAT)) i_i2c_scl_tap_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .div_code_i   (div_code),
      .enable_i     (enable),
      .run_i        (run),
      .scl_fall_o   (scl_fall),
      .scl_rise_o   (scl_rise),
      .sda_change_o (sda_change)
   );

   function automatic int exp_half(int c);
      int sclt[8] = '{9, 10, 12, 15, 5, 6, 7, 8};
      int base[8] = '{4, 4, 6, 6, 14, 30, 62, 126};
      int a = (c & 3) | (((c >> 5) & 1) << 2);
      int b = (c >> 2) & 7;
      return base[b] + (sclt[a] - 1) * (1 << b) + 2;
   endfunction

   function automatic int exp_hold(int c);
      int sdat[8] = '{3, 3, 4, 4, 1, 1, 2, 2};
      int base[8] = '{4, 4, 6, 6, 14, 30, 62, 126};
      int a = (c & 3) | (((c >> 5) & 1) << 2);
      int b = (c >> 2) & 7;
      return base[b] + (sdat[a] - 1) * (1 << b) + 3;
   endfunction

   task automatic chk(string req, int act_v, int exp_v);
      nchk++;
      if (act_v != exp_v) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
      end
   endtask

   task automatic clear_rec();
      nf = 0; nr = 0; ns = 0; t = 0;
      for (int k = 0; k < 4; k++) begin
         f_t[k] = -1; r_t[k] = -1; s_t[k] = -1;
      end
   endtask

   task automatic watch(int n, int chg_at, logic [5:0] chg_code, int drop_at);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         t++;
         if (scl_fall + scl_rise + sda_change > 1) multi++;
         if (scl_fall)   begin if (nf < 4) f_t[nf] = t; nf++; end
         if (scl_rise)   begin if (nr < 4) r_t[nr] = t; nr++; end
         if (sda_change) begin if (ns < 4) s_t[ns] = t; ns++; end
         if (t == chg_at)  div_code = chg_code;
         if (t == drop_at) run = 1'b0;
      end
   endtask

   task automatic begin_run(logic [5:0] c);
      @(negedge clk);
      run = 1'b0;
      div_code = c;
      @(negedge clk);
      @(negedge clk);
      clear_rec();
      run = 1'b1;
   endtask

   initial begin
      int p, h, tot;
      multi = 0;
      // R11: reset quiet even with run requested
      tot = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         tot += scl_fall + scl_rise + sda_change;
      end
      chk("R11 strobes in reset", tot, 0);
      run = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // Sweep of all codes (R1 R2 decode through R3 R4 R5 R7)
      for (int c = 0; c < 64; c++) begin
         p = 2 * exp_half(c);
         h = exp_hold(c);
         begin_run(6'(c));
         watch(p + LAT + 3, -1, 6'd0, -1);
         chk($sformatf("R7 first fall code %0d", c), f_t[0], 1 + LAT);
         chk($sformatf("R3 period code %0d (R1 R2)", c), f_t[1] - f_t[0], p);
         chk($sformatf("R4 rise code %0d", c), r_t[0] - f_t[0], p / 2);
         chk($sformatf("R5 hold code %0d", c), s_t[0] - f_t[0], h);
         if (c == 'h00) begin
            chk("R6 period 0x00", f_t[1] - f_t[0], 28);
            chk("R6 hold 0x00", s_t[0] - f_t[0], 9);
         end
         if (c == 'h3F) begin
            chk("R6 period 0x3F", f_t[1] - f_t[0], 2048);
            chk("R6 hold 0x3F", s_t[0] - f_t[0], 257);
         end
         if (c == 'h20) begin
            chk("R6 period 0x20", f_t[1] - f_t[0], 20);
            chk("R6 hold 0x20", s_t[0] - f_t[0], 7);
         end
         if (c == 'h1F) begin
            chk("R6 period 0x1F", f_t[1] - f_t[0], 3840);
            chk("R6 hold 0x1F", s_t[0] - f_t[0], 513);
         end
      end

      // R8: code change mid-period applies at next boundary
      begin_run(6'h00);
      watch(28 + 20 + LAT + 4, 5, 6'h20, -1);
      chk("R8 old period kept", f_t[1] - f_t[0], 28);
      chk("R8 old rise kept", r_t[0] - f_t[0], 14);
      chk("R8 new period", f_t[2] - f_t[1], 20);
      chk("R8 new rise", r_t[1] - f_t[1], 10);

      // R9: run dropped mid-period, then restarted
      begin_run(6'h00);
      watch(40, -1, 6'd0, 20);
      chk("R9 falls after drop", nf, 1);
      chk("R9 rises after drop", nr, 1);
      clear_rec();
      run = 1'b1;
      watch(LAT + 3, -1, 6'd0, -1);
      chk("R9 restart fresh period", f_t[0], 1 + LAT);

      // R9: enable low blocks the run request
      @(negedge clk);
      enable = 1'b0;
      begin_run(6'h20);
      watch(60, -1, 6'd0, -1);
      chk("R9 strobes with enable low", nf + nr + ns, 0);
      clear_rec();
      enable = 1'b1;
      watch(LAT + 3, -1, 6'd0, -1);
      chk("R9 enable restores timing", f_t[0], 1 + LAT);

      chk("R10 cycles with several strobes", multi, 0);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule